// File: doc/BRIEF.md
# Offload Issue and Commit Tracker

This block sits on the coprocessor side of an instruction offload link. A host core presents instructions it cannot execute itself, one request at a time, with a privilege mode, a transaction ID and per-operand valid flags. The block decodes a small fixed set of custom opcodes and answers in the same cycle with ready, accept and three hint flags. The hints say whether the instruction writes a destination register, whether it is a memory operation, and whether it may raise a synchronous fault. A request counts as taken on a rising clock edge where valid and ready are both high. The host may withdraw a waiting request by dropping valid, or replace it by presenting a different ID while valid stays high.

Accepted instructions are speculative. For every request that is taken, the host later sends one commit message carrying the ID and a kill bit. The block keeps one tracking slot per possible ID value. A slot moves from free to issued when its request is accepted, then to committed, and back to free. It returns to free when the kill bit arrives or when the result handshake completes. A downstream execution stage offers finished work by ID. The block forwards that work to the host's result channel only when the ID has been committed without kill, which may be in the commit cycle itself. Work for an ID that is still speculative is held. Work for a free ID is consumed and dropped.

Top module: `offload_tracker`

## Requirements
- R1: After reset every slot is free: offering work for any ID gives result_valid_o = 0 and exe_ready_o = 1.
- R2: Supported instructions are those with opcode bits [6:0] = 0x0B (two-operand ALU), 0x2B (three-operand, accepted only when bits [26:25] = 00), and 0x5B with bits [14:12] = 000 (load) or 001 (store). Any other instruction gives ready = 1 and accept = 0. Accept never rises without ready.
- R3: Operand needs are as follows. The ALU opcode needs rs1 (bits [19:15]) and rs2 (bits [24:20]). The three-operand opcode needs rs1, rs2 and rs3 (bits [31:27]). Load needs rs1, and store needs rs1 and rs2. The valid flag for rs1 is issue_rs_valid_i bit 0, for rs2 bit 1, and for rs3 bit 2. A needed operand whose register field is 0 is treated as available. A supported instruction with a needed flag low gives ready = 0 and accept = 0. Flags for operands the instruction does not need have no effect.
- R4: Writeback is 1 for ALU, three-operand and load instructions when the destination field (bits [11:7]) is nonzero. Loadstore and exception are both 1 for load and store. All three flags are 0 whenever accept is 0.
- R5: In mode 2'b10 every instruction is rejected (ready 1, accept 0). In mode 2'b00 the memory opcode is rejected, while the other opcodes are still accepted.
- R6: The response follows the request presented in the current cycle, so a request replaced by a new ID allocates nothing. A request whose valid is low at the edge allocates nothing.
- R7: Work offered for an issued, uncommitted ID is held: result_valid_o = 0 and exe_ready_o = 0.
- R8: A commit with kill 0 releases work for the same ID in the commit cycle itself (result_valid_o = 1).
- R9: A committed ID presents its work as result_valid_o = 1. A result handshake (result_valid_o and result_ready_i both high at an edge) frees the slot.
- R10: A commit with kill 1 frees an issued slot. Later work for that ID is dropped (result_valid_o = 0, exe_ready_o = 1).
- R11: A commit for an ID whose request was rejected leaves the slot free, whatever its kill bit.
- R12: While result_ready_i is low, a committed ID keeps result_valid_o high and exe_ready_o low, and the slot stays committed.
- R13: Slots for different IDs change independently, and a freed ID can be issued again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| issue_valid_i | input | 1 | Offload request present |
| issue_ready_o | output | 1 | Request can be taken this cycle |
| issue_instr_i | input | 32 | Offloaded instruction word |
| issue_mode_i | input | 2 | Privilege mode of the request |
| issue_id_i | input | ID_WIDTH | Transaction ID |
| issue_rs_valid_i | input | 3 | Per-operand valid flags (bit 0 rs1, bit 1 rs2, bit 2 rs3) |
| issue_accept_o | output | 1 | Instruction accepted for offload |
| issue_writeback_o | output | 1 | Will write a destination register |
| issue_loadstore_o | output | 1 | Is a memory operation |
| issue_exc_o | output | 1 | May raise a synchronous fault |
| commit_valid_i | input | 1 | Commit message present (one cycle) |
| commit_id_i | input | ID_WIDTH | ID the commit refers to |
| commit_kill_i | input | 1 | Discard the instruction |
| exe_valid_i | input | 1 | Execution stage offers finished work |
| exe_id_i | input | ID_WIDTH | ID of the offered work |
| exe_ready_o | output | 1 | Offered work consumed (released or dropped) |
| result_valid_o | output | 1 | Result presented to host |
| result_ready_i | input | 1 | Host takes result |
| result_id_o | output | ID_WIDTH | ID of the presented result |

## Verification
The bench replaces a request by a new ID while valid stays high. A design that registered the response, or allocated on the stale ID, would leave the withdrawn ID marked busy. It offers work in the very cycle of its commit. Logic that looked only at slot state would hold that work one cycle too long, while logic that ignored the state would release unconfirmed work. It also sends a commit with kill 0 for a rejected ID, stalls the host's ready for several cycles, and kills an issued ID. Wrong handling shows up as a phantom release, a lost result, or a slot that never frees.

// File: rtl/offl_pkg.sv
package offl_pkg;
  localparam int unsigned NUM_RS = 3;

  localparam logic [6:0] OPC_ALU  = 7'h0B;
  localparam logic [6:0] OPC_TERN = 7'h2B;
  localparam logic [6:0] OPC_MEM  = 7'h5B;
  localparam logic [2:0] F3_LOAD  = 3'b000;
  localparam logic [2:0] F3_STORE = 3'b001;
  localparam logic [1:0] MODE_USER = 2'b00;
  localparam logic [1:0] MODE_RSVD = 2'b10;

  typedef enum logic [1:0] {
    SLOT_FREE      = 2'd0,
    SLOT_ISSUED    = 2'd1,
    SLOT_COMMITTED = 2'd2
  } slot_state_e;

  typedef struct packed {
    logic              supported;
    logic [NUM_RS-1:0] need_rs;
    logic              writes_rd;
    logic              is_mem;
    logic              may_fault;
  } dec_t;
endpackage

// File: rtl/offl_decode.sv
module offl_decode
  import offl_pkg::*;
(
  input  logic [31:0] instr_i,
  input  logic [1:0]  mode_i,
  output dec_t        dec_o
);
  logic [6:0]        opc;
  logic [2:0]        f3;
  logic              rd_nz;
  logic [NUM_RS-1:0] rs_nz;

  assign opc   = instr_i[6:0];
  assign f3    = instr_i[14:12];
  assign rd_nz = |instr_i[11:7];
  // x0 reads as zero, so no wait is needed for it
  assign rs_nz = {|instr_i[31:27], |instr_i[24:20], |instr_i[19:15]};

  always_comb begin
    dec_o = '0;
    if (mode_i != MODE_RSVD) begin
      unique case (opc)
        OPC_ALU: begin
          dec_o.supported = 1'b1;
          dec_o.need_rs   = {1'b0, rs_nz[1:0]};
          dec_o.writes_rd = rd_nz;
        end
        OPC_TERN: begin
          if (instr_i[26:25] == 2'b00) begin
            dec_o.supported = 1'b1;
            dec_o.need_rs   = rs_nz;
            dec_o.writes_rd = rd_nz;
          end
        end
        OPC_MEM: begin
          if (mode_i != MODE_USER) begin
            if (f3 == F3_LOAD) begin
              dec_o.supported = 1'b1;
              dec_o.need_rs   = {2'b00, rs_nz[0]};
              dec_o.writes_rd = rd_nz;
              dec_o.is_mem    = 1'b1;
              dec_o.may_fault = 1'b1;
            end else if (f3 == F3_STORE) begin
              dec_o.supported = 1'b1;
              dec_o.need_rs   = {1'b0, rs_nz[1:0]};
              dec_o.is_mem    = 1'b1;
              dec_o.may_fault = 1'b1;
            end
          end
        end
        default: dec_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/offl_slot.sv
module offl_slot
  import offl_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        alloc_i,
  input  logic        commit_i,
  input  logic        kill_i,
  input  logic        release_i,
  output slot_state_e state_o
);
  slot_state_e state_d, state_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SLOT_FREE: begin
        if (alloc_i) state_d = SLOT_ISSUED;
      end
      SLOT_ISSUED: begin
        if (commit_i) begin
          if (kill_i || release_i) state_d = SLOT_FREE;
          else                     state_d = SLOT_COMMITTED;
        end
      end
      SLOT_COMMITTED: begin
        if (release_i) state_d = SLOT_FREE;
      end
      default: state_d = SLOT_FREE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SLOT_FREE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/offl_release.sv
module offl_release
  import offl_pkg::*;
(
  input  logic        exe_valid_i,
  input  slot_state_e exe_state_i,
  input  logic        commit_now_ok_i,
  input  logic        result_ready_i,
  output logic        result_valid_o,
  output logic        exe_ready_o,
  output logic        fire_o
);
  logic cleared;

  assign cleared        = (exe_state_i == SLOT_COMMITTED) || commit_now_ok_i;
  assign result_valid_o = exe_valid_i && cleared;
  // free ID: stale work, consume and drop
  assign exe_ready_o    = (cleared && result_ready_i) || (exe_state_i == SLOT_FREE);
  assign fire_o         = result_valid_o && result_ready_i;
endmodule

// File: rtl/offload_tracker.sv
module offload_tracker
  import offl_pkg::*;
#(
  parameter int unsigned ID_WIDTH = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                issue_valid_i,
  output logic                issue_ready_o,
  input  logic [31:0]         issue_instr_i,
  input  logic [1:0]          issue_mode_i,
  input  logic [ID_WIDTH-1:0] issue_id_i,
  input  logic [NUM_RS-1:0]   issue_rs_valid_i,
  output logic                issue_accept_o,
  output logic                issue_writeback_o,
  output logic                issue_loadstore_o,
  output logic                issue_exc_o,
  input  logic                commit_valid_i,
  input  logic [ID_WIDTH-1:0] commit_id_i,
  input  logic                commit_kill_i,
  input  logic                exe_valid_i,
  input  logic [ID_WIDTH-1:0] exe_id_i,
  output logic                exe_ready_o,
  output logic                result_valid_o,
  input  logic                result_ready_i,
  output logic [ID_WIDTH-1:0] result_id_o
);
  localparam int unsigned NUM_IDS = 1 << ID_WIDTH;

  dec_t        dec;
  logic        ops_ok;
  logic        take;
  logic        commit_now_ok;
  logic        res_fire;
  slot_state_e exe_state;
  slot_state_e slot_state [NUM_IDS];

  offl_decode u_dec (
    .instr_i (issue_instr_i),
    .mode_i  (issue_mode_i),
    .dec_o   (dec)
  );

  assign ops_ok            = &(issue_rs_valid_i | ~dec.need_rs);
  assign issue_ready_o     = !dec.supported || ops_ok;
  assign issue_accept_o    = dec.supported && ops_ok;
  assign issue_writeback_o = issue_accept_o && dec.writes_rd;
  assign issue_loadstore_o = issue_accept_o && dec.is_mem;
  assign issue_exc_o       = issue_accept_o && dec.may_fault;
  assign take              = issue_valid_i && issue_ready_o && issue_accept_o;

  assign exe_state     = slot_state[exe_id_i];
  assign commit_now_ok = commit_valid_i && !commit_kill_i &&
                         (commit_id_i == exe_id_i) && (exe_state == SLOT_ISSUED);

  offl_release u_rel (
    .exe_valid_i     (exe_valid_i),
    .exe_state_i     (exe_state),
    .commit_now_ok_i (commit_now_ok),
    .result_ready_i  (result_ready_i),
    .result_valid_o  (result_valid_o),
    .exe_ready_o     (exe_ready_o),
    .fire_o          (res_fire)
  );

  assign result_id_o = exe_id_i;

  for (genvar g = 0; g < NUM_IDS; g++) begin : g_slot
    localparam logic [ID_WIDTH-1:0] SLOT_ID = ID_WIDTH'(g);
    offl_slot u_slot (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .alloc_i   (take && (issue_id_i == SLOT_ID)),
      .commit_i  (commit_valid_i && (commit_id_i == SLOT_ID)),
      .kill_i    (commit_kill_i),
      .release_i (res_fire && (exe_id_i == SLOT_ID)),
      .state_o   (slot_state[g])
    );
  end
endmodule

// File: rtl/offl_tracker_chk.sv
module offl_tracker_chk #(
  parameter int unsigned ID_WIDTH = 4
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                issue_ready_o,
  input logic [31:0]         issue_instr_i,
  input logic [2:0]          issue_rs_valid_i,
  input logic                issue_accept_o,
  input logic                issue_writeback_o,
  input logic                issue_loadstore_o,
  input logic                issue_exc_o,
  input logic                commit_valid_i,
  input logic [ID_WIDTH-1:0] commit_id_i,
  input logic                commit_kill_i,
  input logic                exe_valid_i,
  input logic [ID_WIDTH-1:0] exe_id_i,
  input logic                result_valid_o,
  input logic                result_ready_i
);
  // R2
  accept_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_accept_o |-> issue_ready_o);

  // R3
  tern_operands_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_accept_o && issue_instr_i[6:0] == 7'h2B && issue_instr_i[31:27] != 5'd0)
      |-> issue_rs_valid_i[2]);

  // R4
  flags_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !issue_accept_o |-> !(issue_writeback_o || issue_loadstore_o || issue_exc_o));

  // R10
  kill_blocks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_valid_i && commit_kill_i) |=>
      !(exe_id_i == $past(commit_id_i) && !commit_valid_i && result_valid_o));

  // R12
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (result_valid_o && !result_ready_i) |=>
      (!(exe_valid_i && exe_id_i == $past(exe_id_i) && !commit_valid_i) || result_valid_o));

  // R9
  free_after_fire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (result_valid_o && result_ready_i) |=>
      (!(exe_valid_i && exe_id_i == $past(exe_id_i) && !commit_valid_i) || !result_valid_o));
endmodule

bind offload_tracker offl_tracker_chk #(.ID_WIDTH(ID_WIDTH)) u_chk (
  .clk_i             (clk_i),
  .rst_ni            (rst_ni),
  .issue_ready_o     (issue_ready_o),
  .issue_instr_i     (issue_instr_i),
  .issue_rs_valid_i  (issue_rs_valid_i),
  .issue_accept_o    (issue_accept_o),
  .issue_writeback_o (issue_writeback_o),
  .issue_loadstore_o (issue_loadstore_o),
  .issue_exc_o       (issue_exc_o),
  .commit_valid_i    (commit_valid_i),
  .commit_id_i       (commit_id_i),
  .commit_kill_i     (commit_kill_i),
  .exe_valid_i       (exe_valid_i),
  .exe_id_i          (exe_id_i),
  .result_valid_o    (result_valid_o),
  .result_ready_i    (result_ready_i)
);

// File: tb/sim_offload_tracker.sv
`timescale 1ns/1ps
module sim_offload_tracker;
  localparam int unsigned IDW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic issue_valid = 1'b0;
  logic issue_ready;
  logic [31:0] issue_instr = '0;
  logic [1:0] issue_mode = 2'b11;
  logic [IDW-1:0] issue_id = '0;
  logic [2:0] issue_rsv = '0;
  logic accept, wb, ls, exc;
  logic commit_valid = 1'b0;
  logic [IDW-1:0] commit_id = '0;
  logic commit_kill = 1'b0;
  logic exe_valid = 1'b0;
  logic [IDW-1:0] exe_id = '0;
  logic exe_ready;
  logic result_valid;
  logic result_ready = 1'b0;
  logic [IDW-1:0] result_id;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  offload_tracker #(.ID_WIDTH(IDW)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .issue_valid_i(issue_valid), .issue_ready_o(issue_ready),
    .issue_instr_i(issue_instr), .issue_mode_i(issue_mode),
    .issue_id_i(issue_id), .issue_rs_valid_i(issue_rsv),
    .issue_accept_o(accept), .issue_writeback_o(wb),
    .issue_loadstore_o(ls), .issue_exc_o(exc),
    .commit_valid_i(commit_valid), .commit_id_i(commit_id), .commit_kill_i(commit_kill),
    .exe_valid_i(exe_valid), .exe_id_i(exe_id), .exe_ready_o(exe_ready),
    .result_valid_o(result_valid), .result_ready_i(result_ready), .result_id_o(result_id)
  );

  typedef struct packed {
    logic [31:0] instr;
    logic [1:0]  mode;
    logic [2:0]  rsv;
    logic [4:0]  exp;   // {ready, accept, writeback, loadstore, exc}
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{32'h0020828B, 2'b11, 3'b011, 5'b11100}, // R2 alu
    '{32'h0020828B, 2'b11, 3'b001, 5'b00000}, // R3 rs2 missing
    '{32'h0020800B, 2'b11, 3'b111, 5'b11000}, // R4 rd x0
    '{32'h182081AB, 2'b11, 3'b011, 5'b00000}, // R3 rs3 missing
    '{32'h182081AB, 2'b11, 3'b111, 5'b11100}, // R2 ternary
    '{32'h000083DB, 2'b11, 3'b001, 5'b11111}, // R4 load
    '{32'h000083DB, 2'b00, 3'b001, 5'b10000}, // R5 load in user
    '{32'h0020905B, 2'b01, 3'b011, 5'b11011}, // R4 store
    '{32'h0020905B, 2'b11, 3'b001, 5'b00000}, // R3 store rs2 missing
    '{32'h0020A05B, 2'b11, 3'b111, 5'b10000}, // R2 bad funct3
    '{32'h00208033, 2'b11, 3'b111, 5'b10000}, // R2 unknown opcode
    '{32'h0020828B, 2'b10, 3'b111, 5'b10000}, // R5 reserved mode
    '{32'h0020828B, 2'b00, 3'b011, 5'b11100}, // R5 alu in user
    '{32'h000083DB, 2'b11, 3'b110, 5'b00000}, // R3 rs1 missing
    '{32'h0020828B, 2'b11, 3'b100, 5'b00000}, // R3 unneeded bit only
    '{32'h0020028B, 2'b11, 3'b010, 5'b11100}, // R3 rs1 is x0
    '{32'h1A2081AB, 2'b11, 3'b111, 5'b10000}  // R2 ternary bad fmt
  };

  localparam logic [31:0] I_ALU = 32'h0020828B;
  localparam logic [31:0] I_BAD = 32'h00208033;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue_pulse(input logic [IDW-1:0] id, input logic [31:0] instr,
                             input logic [2:0] rsv);
    @(negedge clk);
    issue_valid = 1'b1; issue_id = id; issue_instr = instr; issue_rsv = rsv;
    issue_mode = 2'b11;
    @(negedge clk);
    issue_valid = 1'b0;
  endtask

  task automatic commit_pulse(input logic [IDW-1:0] id, input logic kill);
    @(negedge clk);
    commit_valid = 1'b1; commit_id = id; commit_kill = kill;
    @(negedge clk);
    commit_valid = 1'b0;
  endtask

  // offers work for an ID across one edge; checks combinational outputs first
  task automatic probe(input logic [IDW-1:0] id, input logic rdy,
                       input logic exp_rv, input logic exp_er, input string req);
    @(negedge clk);
    exe_valid = 1'b1; exe_id = id; result_ready = rdy;
    #1;
    check({req, " result_valid"}, {31'd0, result_valid}, {31'd0, exp_rv});
    check({req, " exe_ready"}, {31'd0, exe_ready}, {31'd0, exp_er});
    @(posedge clk);
    #1;
    exe_valid = 1'b0; result_ready = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: all slots free after reset
    probe(4'd0, 1'b0, 1'b0, 1'b1, "R1");
    probe(4'd15, 1'b0, 1'b0, 1'b1, "R1");

    // decode table, valid held low so nothing allocates
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      issue_valid = 1'b0; issue_id = '0;
      issue_instr = VECS[i].instr; issue_mode = VECS[i].mode; issue_rsv = VECS[i].rsv;
      #1;
      check($sformatf("R2-5 vec%0d", i), {27'd0, issue_ready, accept, wb, ls, exc},
            {27'd0, VECS[i].exp});
    end
    // R6: accepting content with valid low did not allocate id 0
    probe(4'd0, 1'b0, 1'b0, 1'b1, "R6");

    // R7: held while speculative
    issue_pulse(4'd3, I_ALU, 3'b011);
    probe(4'd3, 1'b0, 1'b0, 1'b0, "R7");

    // R8: release in commit cycle
    @(negedge clk);
    commit_valid = 1'b1; commit_id = 4'd3; commit_kill = 1'b0;
    exe_valid = 1'b1; exe_id = 4'd3; result_ready = 1'b1;
    #1;
    check("R8 result_valid", {31'd0, result_valid}, 32'd1);
    check("R8 result_id", {28'd0, result_id}, 32'd3);
    @(posedge clk);
    #1;
    commit_valid = 1'b0; exe_valid = 1'b0; result_ready = 1'b0;
    probe(4'd3, 1'b0, 1'b0, 1'b1, "R9");

    // R13: freed ID reissued
    issue_pulse(4'd3, I_ALU, 3'b011);
    probe(4'd3, 1'b0, 1'b0, 1'b0, "R13");

    // R12 then R9: stall, then handshake
    issue_pulse(4'd5, I_ALU, 3'b011);
    commit_pulse(4'd5, 1'b0);
    probe(4'd5, 1'b0, 1'b1, 1'b0, "R12");
    probe(4'd5, 1'b0, 1'b1, 1'b0, "R12");
    probe(4'd5, 1'b1, 1'b1, 1'b1, "R9");
    probe(4'd5, 1'b0, 1'b0, 1'b1, "R9");

    // R10: kill frees
    issue_pulse(4'd6, I_ALU, 3'b011);
    commit_pulse(4'd6, 1'b1);
    probe(4'd6, 1'b0, 1'b0, 1'b1, "R10");

    // R11: commit for a rejected request
    issue_pulse(4'd7, I_BAD, 3'b111);
    commit_pulse(4'd7, 1'b0);
    probe(4'd7, 1'b0, 1'b0, 1'b1, "R11");

    // R6: replace id 9 by id 10 while valid stays high
    @(negedge clk);
    issue_valid = 1'b1; issue_id = 4'd9; issue_instr = I_ALU; issue_rsv = 3'b001;
    issue_mode = 2'b11;
    #1;
    check("R3 waiting ready", {31'd0, issue_ready}, 32'd0);
    @(negedge clk);
    issue_id = 4'd10; issue_rsv = 3'b011;
    #1;
    check("R6 new id response", {30'd0, issue_ready, accept}, 32'd3);
    @(negedge clk);
    issue_valid = 1'b0;
    probe(4'd9, 1'b0, 1'b0, 1'b1, "R6");
    probe(4'd10, 1'b0, 1'b0, 1'b0, "R6");

    // R13: independent slots
    issue_pulse(4'd12, I_ALU, 3'b011);
    issue_pulse(4'd13, I_ALU, 3'b011);
    commit_pulse(4'd13, 1'b0);
    probe(4'd12, 1'b0, 1'b0, 1'b0, "R13");
    probe(4'd13, 1'b0, 1'b1, 1'b0, "R13");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule